// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines, keeps a request register, an in-service register and a mask register, and picks the most urgent unmasked request under a rotatable priority order. When a request is allowed through, it raises an interrupt output. A one-cycle acknowledge then captures a vector byte equal to the programmed base plus the line number, and marks that line as in service.

Software reaches the block through two byte-wide addresses: a command port and a data port. Programming is a short fixed sequence of words. A command word with the init bit set starts the sequence. The vector base follows on the data port, then a cascade word (only if single mode was not chosen), then a mode word (only if it was asked for). The cascade word is stored and driven out unchanged. A master writes a bitmask of the lines that have slaves; a slave writes the binary index of the master line it feeds. Once programming is done, data-port writes set the mask. Command-port writes then carry end-of-interrupt, priority-setting and read-select commands.

Top module: `pic_ctrl`

## Requirements
- R1: After reset and before any programming, the data port reads 8'hFF, the interrupt output stays low, and writes to either port are ignored.
- R2: A command write with bit 4 set starts programming. Bit 1 set means single mode, with no cascade word. Bit 0 set means a mode word follows. Bit 3 set selects level triggering. The data writes that follow are taken in order as the base, then the cascade word (driven on `casc_o`), then the mode word. Programming clears the mask and selects request-register reads. Later data writes load the mask, which reads back on the data port.
- R3: An acknowledge pulse while requests are pending loads `vec_o` with base plus the index of the winning line on the next cycle. It also sets that line's in-service bit. In edge mode it clears that line's request bit.
- R4: A set mask bit keeps its line out of priority resolution and out of the interrupt output.
- R5: A command with bits [7:5]=001 and bits [4:3]=00 clears the highest-priority in-service bit. Bits [7:5]=011 clear the in-service bit of the line named in bits [2:0].
- R6: With mode-word bit 1 set (auto end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R7: A command with bits [4:3]=01 and bit 1 set selects the source for command-port reads: bit 0 = 1 gives the in-service register, 0 gives the request register. A command with bit 1 clear leaves the selection unchanged. The selection persists.
- R8: A command with bits [7:5]=110 makes the line in bits [2:0] the lowest priority. Priority then descends from the next line upward, wrapping around. The lowest priority is line 7 after programming.
- R9: In edge mode a request bit is set by a rising edge and is held after the line drops, until it is acknowledged. In level mode the request bit follows the line.
- R10: An acknowledge with no unmasked request pending yields base plus 7 and leaves the in-service register unchanged.
- R11: The interrupt output is raised only for a request of strictly higher priority than every in-service line. With mode-word bit 4 set (fully nested), equal priority also passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a0_i | input | 1 | Port select: 0 command, 1 data |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the port chosen by `a0_i` |
| lines_i | input | 8 | Interrupt request lines |
| ack_i | input | 1 | Acknowledge pulse, one cycle |
| int_o | output | 1 | Interrupt output |
| vec_o | output | 8 | Vector captured at the last acknowledge |
| casc_o | output | 8 | Stored cascade word |

## Verification
The hardest situation to reach is when several requests compete with lines already in service, under every possible choice of lowest-priority line. The bench gets there in two steps. First it sweeps all 255 nonzero request patterns under each of the eight priority rotations, and works out the expected winner from the rotation arithmetic. It then builds nested in-service states on purpose: it acknowledges a low-priority line, raises an equal-priority request and a lower-priority one, and then a higher one. It clears the nested state with both kinds of end-of-interrupt command. A spurious acknowledge is produced by letting a level request fall before the acknowledge arrives.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PIC_LINES = 8;
    localparam int PIC_IDXW  = $clog2(PIC_LINES);
    localparam int PIC_DW    = 8;

    typedef enum logic [2:0] {
        ST_RAW,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_RUN
    } pic_phase_e;

    typedef struct packed {
        pic_phase_e              phase;
        logic                    want_casc;
        logic                    want_mode;
        logic                    level;
        logic                    auto_eoi;
        logic                    nested;
        logic                    sel_isr;
        logic [PIC_IDXW-1:0]     lowest;
        logic [PIC_DW-1:0]       base;
        logic [PIC_DW-1:0]       casc;
        logic [PIC_DW-1:0]       vec;
        logic [PIC_LINES-1:0]    imr;
        logic [PIC_LINES-1:0]    irr;
        logic [PIC_LINES-1:0]    isr;
        logic [PIC_LINES-1:0]    prev;
    } pic_state_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] low_i,
    output logic         hit_o,
    output logic [W-1:0] idx_o
);
    logic [W-1:0] pos;

    // Scan from the lowest priority up to the highest, so the last match wins.
    always_comb begin
        hit_o = 1'b0;
        idx_o = low_i;
        pos   = low_i;
        for (int k = N; k >= 1; k--) begin
            pos = low_i + W'(k);
            if (vec_i[pos]) begin
                hit_o = 1'b1;
                idx_o = pos;
            end
        end
    end
endmodule

// File: rtl/pic_irq_latch.sv
module pic_irq_latch #(
    parameter int N = 8
) (
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] irr_i,
    input  logic         level_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] irr_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        always_comb begin
            if (level_i) begin
                irr_o[g] = lines_i[g];
            end else begin
                irr_o[g] = (irr_i[g] | (lines_i[g] & ~prev_i[g])) & ~clr_i[g];
            end
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int LINES = PIC_LINES,
    parameter int DW    = PIC_DW,
    localparam int IW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a0_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [LINES-1:0] lines_i,
    input  logic          ack_i,
    output logic          int_o,
    output logic [DW-1:0] vec_o,
    output logic [DW-1:0] casc_o
);
    pic_state_t s_q, s_d;

    logic [LINES-1:0] req;
    logic             req_hit, isr_hit;
    logic [IW-1:0]    req_idx, isr_idx;
    logic [IW-1:0]    req_rank, isr_rank;
    logic [LINES-1:0] ack_clr;
    logic [LINES-1:0] irr_next;
    logic             running;
    logic             ack_take;

    assign running = (s_q.phase == ST_RUN);
    assign req     = s_q.irr & ~s_q.imr;

    pic_prio #(.N(LINES)) u_req_prio (
        .vec_i (req),
        .low_i (s_q.lowest),
        .hit_o (req_hit),
        .idx_o (req_idx)
    );

    pic_prio #(.N(LINES)) u_isr_prio (
        .vec_i (s_q.isr),
        .low_i (s_q.lowest),
        .hit_o (isr_hit),
        .idx_o (isr_idx)
    );

    // Rank 0 is the highest priority.
    assign req_rank = req_idx - s_q.lowest - IW'(1);
    assign isr_rank = isr_idx - s_q.lowest - IW'(1);

    assign ack_take = ack_i && running && req_hit;
    always_comb begin
        ack_clr = '0;
        if (ack_take) ack_clr[req_idx] = 1'b1;
    end

    pic_irq_latch #(.N(LINES)) u_latch (
        .lines_i (lines_i),
        .prev_i  (s_q.prev),
        .irr_i   (s_q.irr),
        .level_i (s_q.level),
        .clr_i   (ack_clr),
        .irr_o   (irr_next)
    );

    always_comb begin
        s_d      = s_q;
        s_d.prev = lines_i;
        s_d.irr  = irr_next;

        if (wr_i) begin
            if (!a0_i && wdata_i[4]) begin
                s_d.phase     = ST_BASE;
                s_d.want_casc = ~wdata_i[1];
                s_d.want_mode = wdata_i[0];
                s_d.level     = wdata_i[3];
                s_d.auto_eoi  = 1'b0;
                s_d.nested    = 1'b0;
                s_d.sel_isr   = 1'b0;
                s_d.lowest    = IW'(LINES - 1);
                s_d.imr       = '0;
                s_d.isr       = '0;
                s_d.irr       = '0;
            end else if (a0_i) begin
                case (s_q.phase)
                    ST_BASE: begin
                        s_d.base  = wdata_i;
                        s_d.phase = s_q.want_casc ? ST_CASC :
                                    (s_q.want_mode ? ST_MODE : ST_RUN);
                    end
                    ST_CASC: begin
                        s_d.casc  = wdata_i;
                        s_d.phase = s_q.want_mode ? ST_MODE : ST_RUN;
                    end
                    ST_MODE: begin
                        s_d.auto_eoi = wdata_i[1];
                        s_d.nested   = wdata_i[4];
                        s_d.phase    = ST_RUN;
                    end
                    ST_RUN:  s_d.imr = wdata_i[LINES-1:0];
                    default: ;
                endcase
            end else if (running) begin
                if (!wdata_i[3]) begin
                    case (wdata_i[7:5])
                        3'b001: if (isr_hit) s_d.isr[isr_idx] = 1'b0;
                        3'b011: s_d.isr[wdata_i[IW-1:0]] = 1'b0;
                        3'b110: s_d.lowest = wdata_i[IW-1:0];
                        default: ;
                    endcase
                end else if (wdata_i[1]) begin
                    s_d.sel_isr = wdata_i[0];
                end
            end
        end

        if (ack_i && running) begin
            if (req_hit) begin
                s_d.vec = s_q.base + DW'(req_idx);
                if (!s_q.auto_eoi) s_d.isr[req_idx] = 1'b1;
            end else begin
                s_d.vec = s_q.base + DW'(LINES - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase     <= ST_RAW;
            s_q.want_casc <= 1'b0;
            s_q.want_mode <= 1'b0;
            s_q.level     <= 1'b0;
            s_q.auto_eoi  <= 1'b0;
            s_q.nested    <= 1'b0;
            s_q.sel_isr   <= 1'b0;
            s_q.lowest    <= IW'(LINES - 1);
            s_q.base      <= '0;
            s_q.casc      <= '0;
            s_q.vec       <= '0;
            s_q.imr       <= '1;
            s_q.irr       <= '0;
            s_q.isr       <= '0;
            s_q.prev      <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign int_o   = running && req_hit &&
                     (!isr_hit || (req_rank < isr_rank) ||
                      (s_q.nested && (req_rank == isr_rank)));
    assign rdata_o = a0_i ? DW'(s_q.imr) : DW'(s_q.sel_isr ? s_q.isr : s_q.irr);
    assign vec_o   = s_q.vec;
    assign casc_o  = s_q.casc;

    // R1: an unprogrammed controller keeps every line masked.
    p_raw_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == ST_RAW) |-> (s_q.imr == '1));

    // R3: a plain acknowledge adds exactly one in-service bit.
    p_ack_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !s_q.auto_eoi && !wr_i && !s_q.isr[req_idx]) |=>
        ($countones(s_q.isr) == $countones($past(s_q.isr)) + 1));

    // R4: the interrupt output never reflects a masked-only request.
    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((s_q.irr & ~s_q.imr) != '0));

    // R6: auto end-of-interrupt leaves the in-service register alone.
    p_aeoi_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && running && s_q.auto_eoi && !wr_i) |=> $stable(s_q.isr));

    // R10: an acknowledge with nothing pending reports the last line.
    p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && running && !req_hit && !wr_i) |=>
        ((vec_o == $past(s_q.base) + DW'(LINES - 1)) && $stable(s_q.isr)));
endmodule

// File: tb/pic_ctrl_bench.sv
module pic_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a0 = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rd;
    logic [7:0] lines = 8'h00;
    logic       ack = 1'b0;
    logic       int_w;
    logic [7:0] vec;
    logic [7:0] casc;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pic_ctrl u_pic_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .a0_i    (a0),
        .wr_i    (wr),
        .wdata_i (wd),
        .rdata_o (rd),
        .lines_i (lines),
        .ack_i   (ack),
        .int_o   (int_w),
        .vec_o   (vec),
        .casc_o  (casc)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic port, input logic [7:0] d);
        @(negedge clk);
        a0 = port; wd = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        lines = v;
        @(negedge clk);
    endtask

    task automatic rd_port(input logic port, output logic [7:0] d);
        a0 = port;
        #1;
        d = rd;
    endtask

    function automatic int winner(input int low, input int p);
        for (int k = 1; k <= 8; k++) begin
            int idx;
            idx = (low + k) % 8;
            if (p[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and ignored writes
        chk("R1 int low", int_w, 0);
        rd_port(1'b1, r); chk("R1 mask reset", r, 8'hFF);
        put(1'b1, 8'h00);
        rd_port(1'b1, r); chk("R1 data write ignored", r, 8'hFF);
        put(0, 8'h20);
        drive(8'h01);
        chk("R1 no int before init", int_w, 0);
        drive(8'h00);

        // R2: single mode, no mode word, level triggered
        put(0, 8'h1A);
        put(1, 8'h40);
        put(1, 8'h5A);
        rd_port(1'b1, r); chk("R2 mask loads after base", r, 8'h5A);
        chk("R2 cascade untouched", casc, 8'h00);
        put(1, 8'h00);

        // R8 R3 R5: sweep every rotation and pattern
        put(0, 8'h0B);
        for (int low = 0; low < 8; low++) begin
            put(0, 8'hC0 | 8'(low));
            for (int p = 1; p < 256; p++) begin
                int e;
                e = winner(low, p);
                drive(8'(p));
                chk("R11 int with empty isr", int_w, 1);
                pulse_ack();
                chk("R8 R3 vector", vec, 8'h40 + e);
                rd_port(1'b0, r); chk("R3 isr bit", r, 1 << e);
                put(0, 8'h20);
                rd_port(1'b0, r); chk("R5 nonspecific eoi", r, 0);
            end
        end
        drive(8'h00);
        put(0, 8'hC7);

        // R4: masking
        put(1, 8'h08);
        drive(8'h08);
        chk("R4 masked line quiet", int_w, 0);
        drive(8'h0C);
        chk("R4 unmasked line raises", int_w, 1);
        pulse_ack();
        chk("R4 masked line skipped", vec, 8'h42);
        put(0, 8'h20);
        drive(8'h00);
        put(1, 8'h00);

        // R11 R5: nesting and both end-of-interrupt kinds
        drive(8'h08);
        pulse_ack();
        rd_port(1'b0, r); chk("R3 isr line 3", r, 8'h08);
        drive(8'h28);
        chk("R11 equal or lower blocked", int_w, 0);
        drive(8'h0A);
        chk("R11 higher passes", int_w, 1);
        pulse_ack();
        chk("R11 nested vector", vec, 8'h41);
        rd_port(1'b0, r); chk("R11 two in service", r, 8'h0A);
        put(0, 8'h20);
        rd_port(1'b0, r); chk("R5 highest cleared", r, 8'h08);
        put(0, 8'h63);
        rd_port(1'b0, r); chk("R5 specific cleared", r, 8'h00);
        drive(8'h00);

        // R7: read select persistence
        drive(8'h30);
        rd_port(1'b0, r); chk("R7 isr selected", r, 8'h00);
        put(0, 8'h08);
        rd_port(1'b0, r); chk("R7 selection kept", r, 8'h00);
        put(0, 8'h0A);
        rd_port(1'b0, r); chk("R7 irr selected", r, 8'h30);
        rd_port(1'b0, r); chk("R7 irr persists", r, 8'h30);
        drive(8'h00);

        // R10: spurious acknowledge
        put(0, 8'h0B);
        drive(8'h10);
        chk("R10 int before drop", int_w, 1);
        drive(8'h00);
        pulse_ack();
        chk("R10 spurious vector", vec, 8'h47);
        rd_port(1'b0, r); chk("R10 isr untouched", r, 8'h00);

        // R2 R9 R11: full sequence, master cascade, edge, fully nested
        put(0, 8'h11);
        put(1, 8'h80);
        put(1, 8'h04);
        put(1, 8'h10);
        chk("R2 master cascade word", casc, 8'h04);
        rd_port(1'b1, r); chk("R2 mask cleared by init", r, 8'h00);
        drive(8'h20);
        drive(8'h00);
        rd_port(1'b0, r); chk("R9 edge held after drop", r, 8'h20);
        chk("R9 edge raises int", int_w, 1);
        pulse_ack();
        chk("R3 edge vector", vec, 8'h85);
        rd_port(1'b0, r); chk("R9 edge cleared by ack", r, 8'h00);
        put(0, 8'h0B);
        rd_port(1'b0, r); chk("R3 edge isr", r, 8'h20);
        drive(8'h20);
        chk("R11 fully nested equal passes", int_w, 1);
        put(0, 8'h20);
        rd_port(1'b0, r); chk("R5 eoi in nested mode", r, 8'h00);
        drive(8'h00);

        // R2 R6: slave cascade index and auto end-of-interrupt
        put(0, 8'h11);
        put(1, 8'h90);
        put(1, 8'h02);
        put(1, 8'h03);
        chk("R2 slave cascade word", casc, 8'h02);
        drive(8'h01);
        pulse_ack();
        chk("R6 vector", vec, 8'h90);
        put(0, 8'h0B);
        rd_port(1'b0, r); chk("R6 isr stays clear", r, 8'h00);
        drive(8'h00);

        finish_run();
    end
endmodule